// File: doc/BRIEF.md
# Loop and Condition Branch Resolver

This block settles the program-flow result of three control instructions in a core with 16-bit opcodes. Each cycle it may take one instruction: the opcode, the optional 16-bit extension word that follows it, the opcode's address, the four condition flags, and the value of the data register named by the opcode. One cycle later it reports the next fetch address, plus any write-back that the instruction needs.

The three forms are handled as follows:

- **Flag-tested jump.** It jumps when its condition holds. One condition value makes the jump unconditional, and another makes it a call that also reports a return address.
- **Counted loop.** It leaves the loop at once when its condition holds. Otherwise it counts the low half of a data register down by one and jumps back, unless the count has just wrapped to all ones.
- **Flag-to-byte.** It yields a byte of all ones or all zeros for a store that happens elsewhere.

The flags are only read and are never changed. The same holds for fetch, address generation and memory access: this block reads nothing from them and changes none of them.

Top module: `loop_branch_unit`

## Requirements
- R1: While `rst` is high, and on the first output cycle after it, `out_valid`, `reg_wr_en`, `set_wr_en`, `link_en` and `unhandled` are all 0.
- R2: For an opcode of the form `0110 0000 dddddddd`, `next_pc` is always the target. For an opcode of the form `0110 0001 dddddddd`, the jump is always taken, `link_en` is 1, and `link_addr` is the fall-through address. All addresses here use base = `pc` + 2.
- R3: For an opcode `0110 cccc dddddddd` with cccc from 2 to 15, `next_pc` is base + sign-extended d when the condition holds, and base otherwise. The condition is selected by cccc from the flags `flags[3]`=N, `flags[2]`=Z, `flags[1]`=V, `flags[0]`=C, with this encoding:
  - 2: !C&!Z
  - 3: C|Z
  - 4: !C
  - 5: C
  - 6: !Z
  - 7: Z
  - 8: !V
  - 9: V
  - 10: !N
  - 11: N
  - 12: N==V
  - 13: N!=V
  - 14: !Z&(N==V)
  - 15: Z|(N!=V)
- R4: For the jump form, when the low opcode byte is 0, the sign-extended `ext_word` is used as the displacement and the fall-through address is base + 2.
- R5: For a loop opcode `0101 cccc 11001 rrr` whose condition holds (cccc 0 means true, 1 means false, otherwise as in R3), `reg_wr_en` is 0 and `next_pc` is base + 2.
- R6: For a loop opcode whose condition fails, `reg_wr_en` is 1 and `reg_wr_idx` is rrr. `reg_wr_data` has bits [15:0] equal to `dreg[15:0]` − 1 modulo 2^16, with bits [31:16] unchanged. `next_pc` is base + 2 if the new low half is FFFFh, and base + sign-extended `ext_word` otherwise.
- R7: For an opcode `0101 cccc 11 aaaaaa` with aaaaaa[5:3] ≠ 001, `set_wr_en` is 1, `set_ea` is aaaaaa, `set_byte` is FFh if the condition holds and 00h if not, and `next_pc` is base.
- R8: Any other opcode gives `unhandled` = 1, no write enable, and `next_pc` = base. At most one of `reg_wr_en`, `set_wr_en` and `link_en` is 1, and none is 1 without `out_valid`.
- R9: `out_valid` is `in_valid` delayed by exactly one clock, and every result appears in the cycle after its inputs, back-to-back with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction presented this cycle |
| opcode | input | 16 | First opcode word |
| ext_word | input | 16 | Extension word following the opcode |
| pc | input | 32 | Address of the opcode |
| flags | input | 4 | {N, Z, V, C} |
| dreg | input | 32 | Value of data register rrr |
| out_valid | output | 1 | Result valid |
| next_pc | output | 32 | Next fetch address |
| reg_wr_en | output | 1 | Counter write-back enable |
| reg_wr_idx | output | 3 | Counter register index |
| reg_wr_data | output | 32 | Counter write-back value |
| set_wr_en | output | 1 | Flag-to-byte store request |
| set_ea | output | 6 | Destination mode/register field |
| set_byte | output | 8 | Byte to store |
| link_en | output | 1 | Call: push return address |
| link_addr | output | 32 | Return address |
| unhandled | output | 1 | Opcode not one of the three forms |

## Verification
The bench sweeps every jump condition against all sixteen flag patterns, so a swapped or inverted condition shows up as a wrong `next_pc`. The counter cases cover a low half of 0 wrapping to FFFFh, which must fall through, and a low half of 1 reaching 0, which must still loop. Both use nonzero upper bits, so a design that lets the borrow reach bit 16, or tests the whole register against −1, will fail. A zero short displacement paired with a negative extension word catches a design that skips the wider fall-through address or sign-extends from the wrong width. Nearby opcodes such as `0101 cccc 01...` must come out as unhandled rather than as a loop or a byte store.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

    localparam int OP_W   = 16;
    localparam int EXT_W  = 16;
    localparam int D8_W   = 8;
    localparam int NCOND  = 16;

    typedef enum logic [1:0] {
        FORM_NONE,
        FORM_BRANCH,
        FORM_LOOP,
        FORM_SET
    } form_e;

    typedef enum logic [3:0] {
        CC_T  = 4'd0,  CC_F  = 4'd1,  CC_HI = 4'd2,  CC_LS = 4'd3,
        CC_CC = 4'd4,  CC_CS = 4'd5,  CC_NE = 4'd6,  CC_EQ = 4'd7,
        CC_VC = 4'd8,  CC_VS = 4'd9,  CC_PL = 4'd10, CC_MI = 4'd11,
        CC_GE = 4'd12, CC_LT = 4'd13, CC_GT = 4'd14, CC_LE = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef struct packed {
        form_e              form;
        cond_e              cond;
        logic               is_call;
        logic               use_ext;
        logic [EXT_W-1:0]   disp;
        logic [2:0]         reg_idx;
        logic [5:0]         ea_field;
    } dec_t;

    // Truth of one condition code against the flags.
    function automatic logic cond_eval(input cond_e cc, input flags_t f);
        logic r;
        case (cc)
            CC_T:    r = 1'b1;
            CC_F:    r = 1'b0;
            CC_HI:   r = !f.c && !f.z;
            CC_LS:   r = f.c || f.z;
            CC_CC:   r = !f.c;
            CC_CS:   r = f.c;
            CC_NE:   r = !f.z;
            CC_EQ:   r = f.z;
            CC_VC:   r = !f.v;
            CC_VS:   r = f.v;
            CC_PL:   r = !f.n;
            CC_MI:   r = f.n;
            CC_GE:   r = (f.n == f.v);
            CC_LT:   r = (f.n != f.v);
            CC_GT:   r = !f.z && (f.n == f.v);
            default: r = f.z || (f.n != f.v);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lbu_decode.sv
module lbu_decode
    import lbu_pkg::*;
(
    input  logic [OP_W-1:0]  opcode,
    input  logic [EXT_W-1:0] ext_word,
    output dec_t             dec
);
    localparam logic [3:0] GRP_BRANCH = 4'b0110;
    localparam logic [3:0] GRP_QUICK  = 4'b0101;
    localparam logic [3:0] CC_CALL    = 4'b0001;

    always_comb begin
        dec          = '0;
        dec.form     = FORM_NONE;
        dec.cond     = cond_e'(opcode[11:8]);
        dec.reg_idx  = opcode[2:0];
        dec.ea_field = opcode[5:0];
        if (opcode[15:12] == GRP_BRANCH) begin
            dec.form    = FORM_BRANCH;
            dec.is_call = (opcode[11:8] == CC_CALL);
            if (opcode[D8_W-1:0] == '0) begin
                dec.use_ext = 1'b1;
                dec.disp    = ext_word;
            end else begin
                dec.disp = {{(EXT_W-D8_W){opcode[D8_W-1]}}, opcode[D8_W-1:0]};
            end
        end else if (opcode[15:12] == GRP_QUICK && opcode[7:6] == 2'b11) begin
            if (opcode[5:3] == 3'b001) begin
                dec.form    = FORM_LOOP;
                dec.use_ext = 1'b1;
                dec.disp    = ext_word;
            end else begin
                dec.form = FORM_SET;
            end
        end
    end
endmodule

// File: rtl/lbu_cond.sv
module lbu_cond
    import lbu_pkg::*;
(
    input  cond_e  cond,
    input  flags_t flags,
    output logic   hold
);
    logic [NCOND-1:0] hit;
    logic [3:0]       sel;

    // All conditions evaluated in parallel, then one is picked.
    for (genvar g = 0; g < NCOND; g++) begin : g_cc
        assign hit[g] = cond_eval(cond_e'(4'(g)), flags);
    end

    assign sel  = cond;
    assign hold = hit[sel];
endmodule

// File: rtl/lbu_target.sv
module lbu_target
    import lbu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [EXT_W-1:0]  disp,
    input  logic              use_ext,
    input  logic [DATA_W-1:0] dreg,
    output logic [ADDR_W-1:0] base_pc,
    output logic [ADDR_W-1:0] skip_pc,
    output logic [ADDR_W-1:0] fall_pc,
    output logic [ADDR_W-1:0] tgt_pc,
    output logic [DATA_W-1:0] dec_val,
    output logic              at_end
);
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(2);
    localparam logic [CNT_W-1:0]  ONE        = CNT_W'(1);

    logic [ADDR_W-1:0] disp_x;
    logic [CNT_W-1:0]  cnt_next;

    assign disp_x  = {{(ADDR_W-EXT_W){disp[EXT_W-1]}}, disp};
    assign base_pc = pc + WORD_BYTES;
    assign skip_pc = base_pc + WORD_BYTES;
    assign fall_pc = use_ext ? skip_pc : base_pc;
    assign tgt_pc  = base_pc + disp_x;

    assign cnt_next = dreg[CNT_W-1:0] - ONE;
    assign at_end   = (dreg[CNT_W-1:0] == '0);

    if (CNT_W < DATA_W) begin : g_keep_hi
        assign dec_val = {dreg[DATA_W-1:CNT_W], cnt_next};
    end else begin : g_full
        assign dec_val = cnt_next;
    end
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
    import lbu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [15:0]       opcode,
    input  logic [15:0]       ext_word,
    input  logic [ADDR_W-1:0] pc,
    input  logic [3:0]        flags,
    input  logic [DATA_W-1:0] dreg,
    output logic              out_valid,
    output logic [ADDR_W-1:0] next_pc,
    output logic              reg_wr_en,
    output logic [2:0]        reg_wr_idx,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              set_wr_en,
    output logic [5:0]        set_ea,
    output logic [7:0]        set_byte,
    output logic              link_en,
    output logic [ADDR_W-1:0] link_addr,
    output logic              unhandled
);
    typedef struct packed {
        logic [ADDR_W-1:0] next_pc;
        logic              reg_wr_en;
        logic [2:0]        reg_wr_idx;
        logic [DATA_W-1:0] reg_wr_data;
        logic              set_wr_en;
        logic [5:0]        set_ea;
        logic [7:0]        set_byte;
        logic              link_en;
        logic [ADDR_W-1:0] link_addr;
        logic              unhandled;
    } res_t;

    dec_t              dec;
    flags_t            fl;
    logic              cond_ok;
    logic [ADDR_W-1:0] base_pc, skip_pc, fall_pc, tgt_pc;
    logic [DATA_W-1:0] dec_val;
    logic              at_end;
    res_t              res_d, res_q;
    logic              vld_q;

    assign fl = flags;

    lbu_decode u_decode (
        .opcode   (opcode),
        .ext_word (ext_word),
        .dec      (dec)
    );

    lbu_cond u_cond (
        .cond  (dec.cond),
        .flags (fl),
        .hold  (cond_ok)
    );

    lbu_target #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_target (
        .pc      (pc),
        .disp    (dec.disp),
        .use_ext (dec.use_ext),
        .dreg    (dreg),
        .base_pc (base_pc),
        .skip_pc (skip_pc),
        .fall_pc (fall_pc),
        .tgt_pc  (tgt_pc),
        .dec_val (dec_val),
        .at_end  (at_end)
    );

    always_comb begin
        res_d         = '0;
        res_d.next_pc = base_pc;
        case (dec.form)
            FORM_BRANCH: begin
                res_d.next_pc   = (cond_ok || dec.is_call) ? tgt_pc : fall_pc;
                res_d.link_en   = dec.is_call;
                res_d.link_addr = fall_pc;
            end
            FORM_LOOP: begin
                if (cond_ok) begin
                    res_d.next_pc = skip_pc;
                end else begin
                    res_d.reg_wr_en   = 1'b1;
                    res_d.reg_wr_idx  = dec.reg_idx;
                    res_d.reg_wr_data = dec_val;
                    res_d.next_pc     = at_end ? skip_pc : tgt_pc;
                end
            end
            FORM_SET: begin
                res_d.set_wr_en = 1'b1;
                res_d.set_ea    = dec.ea_field;
                res_d.set_byte  = {8{cond_ok}};
            end
            default: res_d.unhandled = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            res_q <= in_valid ? res_d : '0;
        end
    end

    assign out_valid   = vld_q;
    assign next_pc     = res_q.next_pc;
    assign reg_wr_en   = res_q.reg_wr_en;
    assign reg_wr_idx  = res_q.reg_wr_idx;
    assign reg_wr_data = res_q.reg_wr_data;
    assign set_wr_en   = res_q.set_wr_en;
    assign set_ea      = res_q.set_ea;
    assign set_byte    = res_q.set_byte;
    assign link_en     = res_q.link_en;
    assign link_addr   = res_q.link_addr;
    assign unhandled   = res_q.unhandled;
endmodule

// File: rtl/lbu_checker.sv
module lbu_checker #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [7:0]        op_hi,
    input logic [DATA_W-1:0] dreg,
    input logic              out_valid,
    input logic              reg_wr_en,
    input logic [DATA_W-1:0] reg_wr_data,
    input logic              set_wr_en,
    input logic [7:0]        set_byte,
    input logic              link_en
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !reg_wr_en && !set_wr_en && !link_en));

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_write_gated_R8: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(reg_wr_en || set_wr_en || link_en));

    assert_single_effect_R8: assert property (@(posedge clk) disable iff (rst)
        $countones({reg_wr_en, set_wr_en, link_en}) <= 1);

    assert_count_low_R6: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> (reg_wr_data[CNT_W-1:0] == CNT_W'($past(dreg[CNT_W-1:0]) - CNT_W'(1))));

    if (CNT_W < DATA_W) begin : g_hi_chk
        assert_count_upper_R6: assert property (@(posedge clk) disable iff (rst)
            reg_wr_en |-> (reg_wr_data[DATA_W-1:CNT_W] == $past(dreg[DATA_W-1:CNT_W])));
    end

    assert_byte_levels_R7: assert property (@(posedge clk) disable iff (rst)
        set_wr_en |-> (set_byte == 8'hFF || set_byte == 8'h00));

    assert_call_origin_R2: assert property (@(posedge clk) disable iff (rst)
        link_en |-> ($past(in_valid) && $past(op_hi) == 8'h61));
endmodule

bind loop_branch_unit lbu_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_lbu_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .op_hi       (opcode[15:8]),
    .dreg        (dreg),
    .out_valid   (out_valid),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .set_wr_en   (set_wr_en),
    .set_byte    (set_byte),
    .link_en     (link_en)
);

// File: tb/loop_branch_unit_bench.sv
`timescale 1ns/1ps
module loop_branch_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] opcode = '0;
    logic [15:0] ext_word = '0;
    logic [31:0] pc = '0;
    logic [3:0]  flags = '0;
    logic [31:0] dreg = '0;
    logic        out_valid;
    logic [31:0] next_pc;
    logic        reg_wr_en;
    logic [2:0]  reg_wr_idx;
    logic [31:0] reg_wr_data;
    logic        set_wr_en;
    logic [5:0]  set_ea;
    logic [7:0]  set_byte;
    logic        link_en;
    logic [31:0] link_addr;
    logic        unhandled;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    typedef struct {
        logic [31:0] npc;
        logic        rwe;
        logic [2:0]  ridx;
        logic [31:0] rwd;
        logic        swe;
        logic [5:0]  sea;
        logic [7:0]  sb;
        logic        lnk;
        logic [31:0] la;
        logic        unh;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #4 clk = ~clk;

    loop_branch_unit u_loop_branch_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
        .ext_word(ext_word), .pc(pc), .flags(flags), .dreg(dreg),
        .out_valid(out_valid), .next_pc(next_pc), .reg_wr_en(reg_wr_en),
        .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
        .set_wr_en(set_wr_en), .set_ea(set_ea), .set_byte(set_byte),
        .link_en(link_en), .link_addr(link_addr), .unhandled(unhandled)
    );

    function automatic logic holds(input logic [3:0] c, input logic [3:0] f);
        logic n, z, v, cy;
        {n, z, v, cy} = f;
        case (c)
            4'd0:  return 1'b1;
            4'd1:  return 1'b0;
            4'd2:  return ~(cy | z);
            4'd3:  return cy | z;
            4'd4:  return ~cy;
            4'd5:  return cy;
            4'd6:  return ~z;
            4'd7:  return z;
            4'd8:  return ~v;
            4'd9:  return v;
            4'd10: return ~n;
            4'd11: return n;
            4'd12: return ~(n ^ v);
            4'd13: return n ^ v;
            4'd14: return ~z & ~(n ^ v);
            default: return z | (n ^ v);
        endcase
    endfunction

    function automatic exp_t model(input logic [15:0] op, input logic [15:0] ext,
                                   input logic [31:0] a, input logic [3:0] f,
                                   input logic [31:0] d, input string tag);
        exp_t e;
        logic [31:0] base, tgt, fall;
        logic [15:0] low;
        logic h;
        base  = a + 32'd2;
        h     = holds(op[11:8], f);
        e.npc = base; e.rwe = 1'b0; e.ridx = '0; e.rwd = '0; e.swe = 1'b0;
        e.sea = '0; e.sb = '0; e.lnk = 1'b0; e.la = '0; e.unh = 1'b0; e.tag = tag;
        if (op[15:12] == 4'h6) begin
            if (op[7:0] == 8'h00) begin
                tgt  = base + {{16{ext[15]}}, ext};
                fall = base + 32'd2;
            end else begin
                tgt  = base + {{24{op[7]}}, op[7:0]};
                fall = base;
            end
            if (op[11:8] == 4'h1) begin
                e.lnk = 1'b1; e.la = fall; e.npc = tgt;
            end else begin
                e.npc = h ? tgt : fall;
            end
        end else if (op[15:12] == 4'h5 && op[7:6] == 2'b11 && op[5:3] == 3'b001) begin
            if (h) begin
                e.npc = base + 32'd2;
            end else begin
                low   = d[15:0] - 16'd1;
                e.rwe = 1'b1; e.ridx = op[2:0]; e.rwd = {d[31:16], low};
                e.npc = (low == 16'hFFFF) ? base + 32'd2 : base + {{16{ext[15]}}, ext};
            end
        end else if (op[15:12] == 4'h5 && op[7:6] == 2'b11) begin
            e.swe = 1'b1; e.sea = op[5:0]; e.sb = h ? 8'hFF : 8'h00;
        end else begin
            e.unh = 1'b1;
        end
        return e;
    endfunction

    task automatic cmp(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input logic [15:0] op, input logic [15:0] ext, input logic [31:0] a,
                         input logic [3:0] f, input logic [31:0] d, input string tag);
        @(negedge clk);
        opcode = op; ext_word = ext; pc = a; flags = f; dreg = d; in_valid = 1'b1;
        q.push_back(model(op, ext, a, f, d, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: pops expected items as results emerge (R9 timing).
    always @(negedge clk) begin
        if (!rst && !done && out_valid) begin
            if (q.size() == 0) begin
                cmp("R9", "stray out_valid", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                cmp(e.tag, "next_pc", next_pc, e.npc);
                cmp(e.tag, "reg_wr_en", {31'd0, reg_wr_en}, {31'd0, e.rwe});
                if (e.rwe) begin
                    cmp(e.tag, "reg_wr_data", reg_wr_data, e.rwd);
                    cmp(e.tag, "reg_wr_idx", {29'd0, reg_wr_idx}, {29'd0, e.ridx});
                end
                cmp(e.tag, "set_wr_en", {31'd0, set_wr_en}, {31'd0, e.swe});
                if (e.swe) begin
                    cmp(e.tag, "set_byte", {24'd0, set_byte}, {24'd0, e.sb});
                    cmp(e.tag, "set_ea", {26'd0, set_ea}, {26'd0, e.sea});
                end
                cmp(e.tag, "link_en", {31'd0, link_en}, {31'd0, e.lnk});
                if (e.lnk) cmp(e.tag, "link_addr", link_addr, e.la);
                cmp(e.tag, "unhandled", {31'd0, unhandled}, {31'd0, e.unh});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet outputs while reset is held
        cmp("R1", "out_valid in reset", {31'd0, out_valid}, 32'd0);
        cmp("R1", "enables in reset", {28'd0, reg_wr_en, set_wr_en, link_en, unhandled}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        cmp("R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);

        // R2: always-taken and call
        issue(16'h6010, 16'h0000, 32'h0000_1000, 4'h0, 32'h0, "R2");
        issue(16'h60F0, 16'h0000, 32'h0000_1100, 4'hF, 32'h0, "R2");
        issue(16'h61FC, 16'h0000, 32'h0000_2000, 4'h4, 32'h0, "R2");
        issue(16'h6100, 16'h0100, 32'h0000_3000, 4'h0, 32'h0, "R2");

        // R3: every condition against every flag pattern
        for (int c = 2; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                issue({4'h6, 4'(c), 8'h20}, 16'h0000, 32'h0000_4000 + 32'(c * 64 + f * 4),
                      4'(f), 32'h0, "R3");
            end
        end

        // R4: extension-word displacement
        issue(16'h6600, 16'h8000, 32'h0001_0000, 4'h0, 32'h0, "R4");
        issue(16'h6700, 16'h8000, 32'h0001_0000, 4'h0, 32'h0, "R4");
        issue(16'h6C00, 16'h0100, 32'h0000_5000, 4'hA, 32'h0, "R4");

        // R5: loop exits on a true condition
        issue(16'h50C9, 16'hFFF0, 32'h0000_6000, 4'h0, 32'h0000_0005, "R5");
        issue(16'h57CA, 16'hFFF0, 32'h0000_6100, 4'h4, 32'h0000_0000, "R5");

        // R6: counting down
        issue(16'h51CB, 16'hFFF0, 32'h0000_7000, 4'h0, 32'h1234_0005, "R6");
        issue(16'h51CB, 16'hFFF0, 32'h0000_7000, 4'h0, 32'hABCD_0000, "R6");
        issue(16'h51CE, 16'h0040, 32'h0000_7200, 4'h0, 32'h5555_0001, "R6");
        issue(16'h57CF, 16'hFFFC, 32'h0000_7300, 4'h0, 32'hFFFF_8000, "R6");

        // R7: flag-to-byte
        issue(16'h57C5, 16'h0000, 32'h0000_8000, 4'h4, 32'h0, "R7");
        issue(16'h57C5, 16'h0000, 32'h0000_8000, 4'h0, 32'h0, "R7");
        issue(16'h50FF, 16'h0000, 32'h0000_8100, 4'h0, 32'h0, "R7");
        issue(16'h51D0, 16'h0000, 32'h0000_8200, 4'hF, 32'h0, "R7");

        // R8: neighbouring opcodes that are none of the three forms
        issue(16'h4E75, 16'h0000, 32'h0000_9000, 4'h0, 32'h0, "R8");
        issue(16'h5048, 16'h0000, 32'h0000_9100, 4'h0, 32'h1, "R8");
        issue(16'h7000, 16'h0000, 32'h0000_9200, 4'h0, 32'h1, "R8");
        issue(16'h5088, 16'h0000, 32'h0000_9300, 4'h0, 32'h1, "R8");

        idle(4);
        // R9: every issued instruction produced exactly one result
        cmp("R9", "results outstanding", 32'(q.size()), 32'd0);
        cmp("R9", "out_valid when idle", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule